// File: doc/BRIEF.md
# Device Interrupt Status and Routing Controller

This block collects the interrupt sources of a USB device core into a 10-bit status register and drives two level interrupt lines toward the processor. Single-cycle event pulses from the device core set status bits. Software reads the status word and acknowledges bits by writing ones to a clear register. It can also raise bits itself by writing ones to a set register, which is useful for testing handlers.

An enable register masks which pending sources may reach either line. A priority register picks, for each source, whether it drives the high-priority line or the low-priority line. Two sources are time critical: the frame tick (bit 0) and the fast endpoint (bit 1). Only one of them may be on the high-priority line at a time. If software marks both as high priority, the block treats both as low priority.

The bus side is a plain register port with an address, a write strobe, write data, a read strobe and read data. Read data is combinational and is valid in the cycle of the read strobe.

Top module: `dev_irq_ctrl`

## Requirements
- R1: After reset, the status, enable and priority registers read as zero, and both interrupt outputs are low.
- R2: An event pulse on `evt_i[k]` sets status bit k, which is readable at offset 0x00. The bit positions are: 0 frame, 1 fast endpoint, 2 slow endpoint, 3 device status, 4 command-code empty, 5 command-data full, 6 receive end of packet, 7 transmit end of packet, 8 endpoint realized, 9 endpoint register done.
- R3: Writing to offset 0x08 clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: Writing to offset 0x0C sets each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R5: The enable register at offset 0x04 is read/write. A pending source asserts an interrupt output only if its enable bit is 1.
- R6: In the priority register at offset 0x2C, a 1 routes that enabled, pending source to `irq_hi_o` and a 0 routes it to `irq_lo_o`.
- R7: When priority bits 0 and 1 are both 1, the frame source and the fast endpoint source are both routed to `irq_lo_o` and never to `irq_hi_o`. The register still reads back the value written.
- R8: When an event pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Reads of offsets 0x08 and 0x0C return 0. Bits 31:10 of every read return 0.
- R10: Each interrupt output is registered. It rises one cycle after a qualifying status bit is set and stays high while any qualifying bit remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 10 | Single-cycle event pulses, one per source |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational, zero when no read |
| irq_hi_o | output | 1 | High-priority interrupt level |
| irq_lo_o | output | 1 | Low-priority interrupt level |

## Verification
A hardware event and a software clear can reach the same status bit in the same cycle. The bench provokes this by pulsing the frame event while it writes a one to that bit in the clear register, then reads the status to confirm the bit stayed set. A behavioural model tracks status, enable and priority on every clock and judges both interrupt lines each cycle. This exposes both a lost event and a wrongly routed source in the conflicting-priority case.

// File: rtl/dev_irq_pkg.sv
package dev_irq_pkg;
  localparam int unsigned SRC_N      = 10;
  localparam int unsigned SRC_FRAME  = 0;
  localparam int unsigned SRC_EPFAST = 1;

  typedef enum logic [7:0] {
    OFS_STATUS = 8'h00,
    OFS_ENABLE = 8'h04,
    OFS_CLEAR  = 8'h08,
    OFS_SET    = 8'h0C,
    OFS_PRIO   = 8'h2C
  } reg_ofs_e;
endpackage

// File: rtl/dev_irq_regs.sv
module dev_irq_regs
  import dev_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NSRC   = SRC_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic [NSRC-1:0]   status_i,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   prio_o,
  output logic [NSRC-1:0]   clr_o,
  output logic [NSRC-1:0]   set_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_PRIO   = ADDR_W'(OFS_PRIO);

  logic [NSRC-1:0] en_q, prio_q;
  logic [NSRC-1:0] wbits;

  assign wbits = wdata_i[NSRC-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      prio_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_ENABLE) en_q   <= wbits;
      if (addr_i == A_PRIO)   prio_q <= wbits;
    end
  end

  assign en_o   = en_q;
  assign prio_o = prio_q;
  assign clr_o  = (wr_en_i && addr_i == A_CLEAR) ? wbits : '0;
  assign set_o  = (wr_en_i && addr_i == A_SET)   ? wbits : '0;

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_STATUS: rdata_o = DATA_W'(status_i);
        A_ENABLE: rdata_o = DATA_W'(en_q);
        A_PRIO:   rdata_o = DATA_W'(prio_q);
        default:  rdata_o = '0; // clear/set are write-only
      endcase
    end
  end

  // R9
  wo_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == A_CLEAR || addr_i == A_SET)) |-> (rdata_o == '0));

  // R9
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:NSRC] == '0);
endmodule

// File: rtl/dev_irq_status.sv
module dev_irq_status #(
  parameter int unsigned NSRC = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] set_i,
  output logic [NSRC-1:0] status_o
);
  logic [NSRC-1:0] st_q;

  // set terms applied after clear so an event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~clr_i) | set_i | evt_i;
  end

  assign status_o = st_q;

  // R8
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

  // R3
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~evt_i & ~set_i)) |=> ((status_o & $past(clr_i & ~evt_i & ~set_i)) == '0));
endmodule

// File: rtl/dev_irq_route.sv
module dev_irq_route
  import dev_irq_pkg::*;
#(
  parameter int unsigned NSRC = SRC_N
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] status_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] prio_i,
  output logic            hi_o,
  output logic            lo_o
);
  localparam logic [NSRC-1:0] FAST_PAIR = NSRC'((1 << SRC_FRAME) | (1 << SRC_EPFAST));

  logic            conflict;
  logic [NSRC-1:0] eff_prio;
  logic [NSRC-1:0] pend;
  logic            hi_q, lo_q;

  assign conflict = prio_i[SRC_FRAME] & prio_i[SRC_EPFAST];
  assign pend     = status_i & en_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_prio
    if (g == SRC_FRAME || g == SRC_EPFAST) begin : g_pair
      assign eff_prio[g] = prio_i[g] & ~conflict;
    end else begin : g_plain
      assign eff_prio[g] = prio_i[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= |(pend & eff_prio);
      lo_q <= |(pend & ~eff_prio);
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R7
  fast_pair_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conflict && ((pend & prio_i & ~FAST_PAIR) == '0)) |=> !hi_o);

  // R10
  irq_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_o || lo_o) |-> $past(|pend));
endmodule

// File: rtl/dev_irq_ctrl.sv
module dev_irq_ctrl
  import dev_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NSRC   = SRC_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_hi_o,
  output logic              irq_lo_o
);
  logic [NSRC-1:0] status, en, prio, clr, set;

  dev_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i, .rd_en_i,
    .status_i(status), .en_o(en), .prio_o(prio),
    .clr_o(clr), .set_o(set), .rdata_o
  );

  dev_irq_status #(.NSRC(NSRC)) u_status (
    .clk_i, .rst_ni, .evt_i, .clr_i(clr), .set_i(set), .status_o(status)
  );

  dev_irq_route #(.NSRC(NSRC)) u_route (
    .clk_i, .rst_ni, .status_i(status), .en_i(en), .prio_i(prio),
    .hi_o(irq_hi_o), .lo_o(irq_lo_o)
  );
endmodule

// File: tb/dev_irq_ctrl_bench.sv
module dev_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic        irq_hi, irq_lo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  dev_irq_ctrl u_dev_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .addr_i(addr), .wr_en_i(we),
    .wdata_i(wdata), .rd_en_i(re), .rdata_o(rdata),
    .irq_hi_o(irq_hi), .irq_lo_o(irq_lo)
  );

  // behavioural reference model
  int m_st = 0, m_en = 0, m_pr = 0;
  bit m_hi = 0, m_lo = 0;

  function automatic bit route_hi(int st, int en, int pr);
    bit both_fast = ((pr & 1) != 0) && ((pr & 2) != 0);
    for (int k = 0; k < 10; k++) begin
      bit p = ((st >> k) & (en >> k) & 1) != 0;
      bit h = ((pr >> k) & 1) != 0;
      if (k < 2 && both_fast) h = 0;
      if (p && h) return 1;
    end
    return 0;
  endfunction

  function automatic bit route_lo(int st, int en, int pr);
    bit both_fast = ((pr & 1) != 0) && ((pr & 2) != 0);
    for (int k = 0; k < 10; k++) begin
      bit p = ((st >> k) & (en >> k) & 1) != 0;
      bit h = ((pr >> k) & 1) != 0;
      if (k < 2 && both_fast) h = 0;
      if (p && !h) return 1;
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_en <= 0; m_pr <= 0; m_hi <= 0; m_lo <= 0;
    end else begin
      int nxt;
      m_hi <= route_hi(m_st, m_en, m_pr);
      m_lo <= route_lo(m_st, m_en, m_pr);
      nxt = m_st;
      if (we && addr == 8'h08) nxt = nxt & ~int'(wdata);
      if (we && addr == 8'h0C) nxt = nxt | int'(wdata);
      nxt = (nxt | int'(evt)) & 'h3FF;
      m_st <= nxt;
      if (we && addr == 8'h04) m_en <= int'(wdata) & 'h3FF;
      if (we && addr == 8'h2C) m_pr <= int'(wdata) & 'h3FF;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison of both lines against the model (R6 R7 R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6/R7/R10 irq_hi", {31'd0, irq_hi}, {31'd0, m_hi});
      chk("R6/R7/R10 irq_lo", {31'd0, irq_lo}, {31'd0, m_lo});
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [9:0] e = '0);
    @(negedge clk);
    #1;
    addr = a; wdata = d; we = 1'b1; evt = e;
    @(negedge clk);
    #1;
    we = 1'b0; evt = '0; wdata = '0;
  endtask

  task automatic pulse(logic [9:0] e);
    @(negedge clk);
    #1;
    evt = e;
    @(negedge clk);
    #1;
    evt = '0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    #1;
    addr = a; re = 1'b1;
    #2;
    chk(req, rdata, exp);
    re = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1 status", 8'h00, 0);
    rd("R1 enable", 8'h04, 0);
    rd("R1 prio", 8'h2C, 0);
    chk("R1 irq_hi", {31'd0, irq_hi}, 0);
    chk("R1 irq_lo", {31'd0, irq_lo}, 0);

    // R5 enable readback; R2 frame event
    wr(8'h04, 32'h3FF);
    rd("R5 enable", 8'h04, 32'h3FF);
    @(negedge clk); #1; evt = 10'h001;
    @(negedge clk); #1; evt = '0;
    // R10: status already set, line not yet
    chk("R10 lo one cycle later", {31'd0, irq_lo}, 0);
    @(negedge clk);
    chk("R10 lo asserted", {31'd0, irq_lo}, 1);
    rd("R2 frame bit", 8'h00, 32'h001);
    pulse(10'h300);
    rd("R2 bits 8,9", 8'h00, 32'h301);
    idle(3);
    chk("R10 lo held", {31'd0, irq_lo}, 1);

    // R3 clear
    wr(8'h08, 32'h0);
    rd("R3 zero write no effect", 8'h00, 32'h301);
    wr(8'h08, 32'h101);
    rd("R3 cleared", 8'h00, 32'h200);
    wr(8'h08, 32'h200);
    idle(2);
    chk("R10 lo drops", {31'd0, irq_lo}, 0);

    // R4 set
    wr(8'h0C, 32'h088);
    rd("R4 set", 8'h00, 32'h088);
    wr(8'h0C, 32'h0);
    rd("R4 zero write no effect", 8'h00, 32'h088);
    wr(8'h08, 32'h3FF);

    // R5 mask
    wr(8'h04, 32'h200);
    pulse(10'h004);
    idle(2);
    chk("R5 masked lo", {31'd0, irq_lo}, 0);
    chk("R5 masked hi", {31'd0, irq_hi}, 0);
    rd("R5 status still pending", 8'h00, 32'h004);
    wr(8'h04, 32'h004);
    idle(2);
    chk("R5 unmasked lo", {31'd0, irq_lo}, 1);
    wr(8'h08, 32'h3FF);
    wr(8'h04, 32'h3FF);

    // R6 priority bit 5
    wr(8'h2C, 32'h020);
    pulse(10'h020);
    idle(2);
    chk("R6 hi", {31'd0, irq_hi}, 1);
    chk("R6 lo", {31'd0, irq_lo}, 0);
    pulse(10'h040);
    idle(2);
    chk("R6 both lines", {31'd0, irq_hi & irq_lo}, 1);
    wr(8'h08, 32'h3FF);

    // R7 both fast sources high -> both low
    wr(8'h2C, 32'h003);
    rd("R7 prio readback", 8'h2C, 32'h003);
    pulse(10'h001);
    idle(2);
    chk("R7 frame not hi", {31'd0, irq_hi}, 0);
    chk("R7 frame on lo", {31'd0, irq_lo}, 1);
    pulse(10'h002);
    idle(2);
    chk("R7 epfast not hi", {31'd0, irq_hi}, 0);
    wr(8'h2C, 32'h001);
    idle(2);
    chk("R7 frame hi when alone", {31'd0, irq_hi}, 1);
    chk("R7 epfast lo when alone", {31'd0, irq_lo}, 1);
    wr(8'h08, 32'h3FF);
    wr(8'h2C, 32'h0);

    // R8 event vs clear same cycle
    wr(8'h0C, 32'h003);
    wr(8'h08, 32'h003, 10'h001);
    rd("R8 event wins", 8'h00, 32'h001);

    // R9 write-only and reserved bits
    wr(8'h0C, 32'hFFFF_FFFF);
    rd("R9 status upper zero", 8'h00, 32'h3FF);
    rd("R9 clear reads 0", 8'h08, 0);
    rd("R9 set reads 0", 8'h0C, 0);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd("R9 prio upper zero", 8'h2C, 32'h3FF);
    idle(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule